// File: doc/BRIEF.md
# SPI Slave Word Shifter

This block is the serial front end of a host port that works as an SPI slave. An external host drives a serial clock and an active-low select. The block brings both into the system clock domain through a synchronizer and detects their edges there. While the select is low, every serial clock cycle moves one bit in each direction at the same time. The host picks the word length (8, 16 or 24 bits) for each transaction. A transaction can carry several words back to back.

On the transmit side, the core loads a one-word holding register and watches an empty flag. If the host clocks a new word before the core has refilled the holding register, the previous word goes out again and an underrun flag is set. On the receive side, each completed word leaves as a stream of bytes with a strobe, highest byte first. The block has three separate interrupt outputs: transmit-empty, word received, and bus error. The bus error fires when the select is removed partway through a word. A partial word of that kind is dropped.

Top module: `spi_wm_slave`

## Requirements
- R1: While `ss_n` is high, serial clock activity has no effect: `miso_oe` stays low, and no received byte, `irq_rx` or `irq_berr` appears.
- R2: Bits move most significant bit first. `miso` changes after a falling serial clock edge, and `mosi` is sampled on the rising edge. For a word of length L, the transmitted bits are tx word bits L-1 down to 0.
- R3: `word_mode` selects the word length: 0 gives 8 bits, 1 gives 16 bits, 2 and 3 give 24 bits. The value is captured when the select goes low and holds for the whole transaction, even if `word_mode` changes later.
- R4: A completed word of L bits comes out on `rx_byte` as L/8 bytes on consecutive cycles with `rx_valid` high. The first byte holds the first-received bits. `rx_last` is high only on the final byte.
- R5: `irq_rx` pulses for exactly one cycle per completed word, in the same cycle as that word's first `rx_valid`.
- R6: `tx_wr` fills the holding register and clears `tx_empty`. The start of each word consumes the holding register and sets `tx_empty` again. `irq_tx` equals `tx_empty`.
- R7: If a word starts while the holding register is empty, the last word sent is sent again and `tx_underrun` is set. The next `tx_wr` clears `tx_underrun`.
- R8: If `ss_n` rises with a word partly shifted, `irq_berr` pulses once, no byte and no `irq_rx` is produced for that word, and the next transaction starts from bit 0.
- R9: Within one select period, the falling edge that follows a word's last rising edge starts the next word. That edge consumes the holding register and drives the next word's top bit.
- R10: After reset, `tx_empty` and `irq_tx` are 1, and `tx_underrun`, `miso_oe`, `miso`, `rx_valid`, `irq_rx` and `irq_berr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` while selected |
| word_mode | input | 2 | Word length select |
| tx_data | input | 24 | Transmit word for the holding register |
| tx_wr | input | 1 | Load strobe for `tx_data` |
| tx_empty | output | 1 | Holding register is empty |
| tx_underrun | output | 1 | A word started with no fresh data |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | Strobe for `rx_byte` |
| rx_last | output | 1 | Marks the final byte of a word |
| irq_rx | output | 1 | Word received pulse |
| irq_tx | output | 1 | Transmit-empty interrupt level |
| irq_berr | output | 1 | Bus-error pulse |

## Verification
The bench builds the block with its default two-stage synchronizer and drives the serial clock with a half period of six system clocks. That rate leaves enough margin for the three-cycle sync and edge delay that every sample and every word reload lands inside one serial half period. The stimulus covers all four `word_mode` codes and transactions of one to three words. It refills the transmit register or deliberately starts starved. It also removes the select at random bit positions, which reaches the underrun, reload and bus-error paths at every word length.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  localparam int MAX_W  = 24;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(MAX_W + 1);
  localparam int NB_W   = $clog2(MAX_W / BYTE_W + 1);

  typedef enum logic [1:0] {
    WM_8   = 2'd0,
    WM_16  = 2'd1,
    WM_24  = 2'd2,
    WM_24X = 2'd3
  } wmode_e;

  // bits per word for a mode code
  function automatic logic [CNT_W-1:0] word_len(input wmode_e m);
    case (m)
      WM_8:    return CNT_W'(8);
      WM_16:   return CNT_W'(16);
      default: return CNT_W'(24);
    endcase
  endfunction

  // bytes per word for a mode code
  function automatic logic [NB_W-1:0] byte_count(input wmode_e m);
    return NB_W'(word_len(m) / CNT_W'(BYTE_W));
  endfunction

  // top bit of an L-bit word held in the low bits
  function automatic logic msb_pick(input logic [MAX_W-1:0] w,
                                    input logic [CNT_W-1:0] len);
    return w[len - 1'b1];
  endfunction

  // move an L-bit word to the top of the register
  function automatic logic [MAX_W-1:0] left_align(input logic [MAX_W-1:0] w,
                                                  input logic [CNT_W-1:0] len);
    return w << (CNT_W'(MAX_W) - len);
  endfunction
endpackage

// File: rtl/spi_wm_sync.sv
module spi_wm_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  logic [STAGES:0][N-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {(STAGES+1){RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/spi_wm_txhold.sv
module spi_wm_txhold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic [W-1:0] word,
  output logic         empty,
  output logic         underrun
);
  logic         full;
  logic [W-1:0] hold;
  logic [W-1:0] last;

  // a starved start reuses the previous word
  assign word  = full ? hold : last;
  assign empty = ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      hold     <= '0;
      last     <= '0;
      underrun <= 1'b0;
    end else begin
      if (take) last <= word;
      if (wr) begin
        hold     <= wdata;
        full     <= 1'b1;
        underrun <= 1'b0;
      end else if (take) begin
        full <= 1'b0;
        if (!full) underrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_wm_rxemit.sv
module spi_wm_rxemit #(
  parameter int W   = 24,
  parameter int BW  = 8,
  parameter int NBW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   word,
  input  logic [NBW-1:0] nbytes,
  output logic [BW-1:0]  byte_o,
  output logic           valid,
  output logic           last
);
  logic [W-1:0]   sh;
  logic [NBW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= word;
      left <= nbytes;
    end else if (left != '0) begin
      sh   <= sh << BW;
      left <= left - 1'b1;
    end
  end

  assign valid  = (left != '0);
  assign last   = (left == NBW'(1));
  assign byte_o = sh[W-1 -: BW];
endmodule

// File: rtl/spi_wm_slave.sv
module spi_wm_slave
  import spi_wm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [1:0]        word_mode,
  input  logic [MAX_W-1:0]  tx_data,
  input  logic              tx_wr,
  output logic              tx_empty,
  output logic              tx_underrun,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_last,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_berr
);
  // synchronized pins: {mosi, sclk, ss_n}
  logic [2:0] syn, syn_d;
  logic       unused_mosi_d;

  spi_wm_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({mosi, sclk, ss_n}), .q(syn), .q_prev(syn_d)
  );
  assign unused_mosi_d = syn_d[2];

  // named events
  logic mosi_q, sel_q, sel_qd;
  logic sel_start, sel_end, sck_rise, sck_fall;
  logic word_done, take, berr_evt;

  assign mosi_q    = syn[2];
  assign sel_q     = ~syn[0];
  assign sel_qd    = ~syn_d[0];
  assign sel_start = sel_q & ~sel_qd;
  assign sel_end   = ~sel_q & sel_qd;
  assign sck_rise  = sel_q & syn[1] & ~syn_d[1];
  assign sck_fall  = sel_q & ~syn[1] & syn_d[1];

  wmode_e             mode_q;
  logic [CNT_W-1:0]   len, bitcnt;
  logic [MAX_W-1:0]   tx_sh, rx_sh, rx_word, tx_word;
  logic               reload_pend, oe_q, irq_rx_q, irq_berr_q;

  assign len       = word_len(mode_q);
  assign word_done = sck_rise && (bitcnt == len - 1'b1);
  assign take      = sel_start | (sck_fall & reload_pend);
  assign berr_evt  = sel_end && (bitcnt != '0);
  assign rx_word   = {rx_sh[MAX_W-2:0], mosi_q};

  spi_wm_txhold #(.W(MAX_W)) u_txhold (
    .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data), .take(take),
    .word(tx_word), .empty(tx_empty), .underrun(tx_underrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= WM_8;
      bitcnt      <= '0;
      tx_sh       <= '0;
      rx_sh       <= '0;
      reload_pend <= 1'b0;
      oe_q        <= 1'b0;
      irq_rx_q    <= 1'b0;
      irq_berr_q  <= 1'b0;
    end else begin
      oe_q       <= sel_q;
      irq_rx_q   <= word_done;
      irq_berr_q <= berr_evt;
      if (sel_start) begin
        mode_q      <= wmode_e'(word_mode);
        bitcnt      <= '0;
        reload_pend <= 1'b0;
        tx_sh       <= tx_word;
      end else if (sel_end) begin
        bitcnt      <= '0;
        reload_pend <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh <= rx_word;
          if (word_done) begin
            bitcnt      <= '0;
            reload_pend <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        if (sck_fall) begin
          if (reload_pend) begin
            tx_sh       <= tx_word;
            reload_pend <= 1'b0;
          end else begin
            tx_sh <= tx_sh << 1;
          end
        end
      end
    end
  end

  spi_wm_rxemit #(.W(MAX_W), .BW(BYTE_W), .NBW(NB_W)) u_rxemit (
    .clk(clk), .rst_n(rst_n), .load(word_done),
    .word(left_align(rx_word, len)), .nbytes(byte_count(mode_q)),
    .byte_o(rx_byte), .valid(rx_valid), .last(rx_last)
  );

  assign miso     = oe_q & msb_pick(tx_sh, len);
  assign miso_oe  = oe_q;
  assign irq_rx   = irq_rx_q;
  assign irq_berr = irq_berr_q;
  assign irq_tx   = tx_empty;
endmodule

// File: rtl/spi_wm_slave_chk.sv
module spi_wm_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ss_n,
  input logic miso_oe,
  input logic tx_wr,
  input logic tx_empty,
  input logic tx_underrun,
  input logic rx_valid,
  input logic rx_last,
  input logic irq_rx,
  input logic irq_berr,
  input logic take
);
  // deselected long enough for the sync chain: output stays off
  p_quiet_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ss_n, 2) && $past(ss_n, 3) && $past(ss_n, 4)) |-> !miso_oe);

  p_stream_until_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_last) |=> rx_valid);

  p_irq_with_first_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_valid);

  p_load_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty);

  p_take_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tx_wr) |=> tx_empty);

  p_underrun_from_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underrun) |-> $past(tx_empty));

  p_rx_berr_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_berr));
endmodule

bind spi_wm_slave spi_wm_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .miso_oe(miso_oe),
  .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_underrun(tx_underrun),
  .rx_valid(rx_valid), .rx_last(rx_last), .irq_rx(irq_rx),
  .irq_berr(irq_berr), .take(take)
);

// File: tb/spi_wm_slave_tb.sv
module spi_wm_slave_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, sclk, ss_n, mosi, tx_wr;
  logic [1:0]  word_mode;
  logic [23:0] tx_data;
  logic        miso, miso_oe, tx_empty, tx_underrun, rx_valid, rx_last;
  logic        irq_rx, irq_tx, irq_berr;
  logic [7:0]  rx_byte;

  spi_wm_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .word_mode(word_mode), .tx_data(tx_data),
    .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_underrun(tx_underrun),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_berr(irq_berr)
  );

  localparam int HALF = 6;
  int total = 0, bad = 0;
  int n_irq_rx = 0, n_berr = 0;
  logic [8:0] rxq[$];
  logic [8:0] expq[$];

  // bench model of the holding register
  bit          m_full = 0, m_under = 0;
  logic [23:0] m_hold = '0, m_last = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int blen(input logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 16 : 24;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) rxq.push_back({rx_last, rx_byte});
      if (irq_rx) n_irq_rx++;
      if (irq_berr) n_berr++;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [23:0] d);
    @(negedge clk);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    m_hold = d; m_full = 1; m_under = 0;
  endtask

  task automatic m_start(output logic [23:0] w);
    if (m_full) begin w = m_hold; m_full = 0; end
    else begin w = m_last; m_under = 1; end
    m_last = w;
  endtask

  // abort_bits > 0: select removed after that many bits of the last word
  task automatic txn(input logic [1:0] mode, input int nwords, input int abort_bits,
                     input int give_mask, input bit flip);
    logic [23:0] cur;
    int L, done_words;
    L = blen(mode);
    done_words = 0;
    n_irq_rx = 0; n_berr = 0;
    rxq.delete(); expq.delete();
    @(negedge clk);
    word_mode = mode; ss_n = 1'b0;
    wait_clk(8);
    m_start(cur);
    for (int k = 0; k < nwords; k++) begin
      logic [23:0] mw;
      logic [23:0] got;
      int lim, errs;
      mw = 24'($urandom);
      got = '0; errs = 0;
      lim = (k == nwords - 1 && abort_bits > 0) ? abort_bits : L;
      for (int b = 0; b < lim; b++) begin
        mosi = mw[L-1-b];
        wait_clk(HALF);
        got[L-1-b] = miso;
        if (miso !== cur[L-1-b] || miso_oe !== 1'b1) errs++;
        sclk = 1'b1;
        wait_clk(HALF);
        if (b == 0 && flip) word_mode = ~mode;
        if (b == 0 && give_mask[k]) write_tx(24'($urandom));
        sclk = 1'b0;
      end
      check(errs == 0, "R2", "miso word", got, cur & ((24'h1 << lim) - 1) << (L - lim));
      if (lim == L) begin
        for (int i = 0; i < L / 8; i++)
          expq.push_back({(i == L / 8 - 1), mw[L-1-8*i -: 8]});
        done_words++;
        m_start(cur);  // R9: trailing falling edge starts the next word
      end
    end
    wait_clk(HALF);
    ss_n = 1'b1;
    wait_clk(10);
    begin
      bit same;
      same = (rxq.size() == expq.size());
      if (same) foreach (expq[i]) if (rxq[i] !== expq[i]) same = 0;
      check(same, flip ? "R3" : "R4", "rx byte stream size",
            32'(rxq.size()), 32'(expq.size()));
    end
    check(n_irq_rx == done_words, "R5", "irq_rx count", n_irq_rx, done_words);
    check(n_berr == ((abort_bits > 0) ? 1 : 0), "R8", "irq_berr count",
          n_berr, (abort_bits > 0) ? 1 : 0);
    check(tx_empty == !m_full && irq_tx == tx_empty, "R6", "tx_empty",
          tx_empty, !m_full);
    check(tx_underrun == m_under, "R7", "tx_underrun", tx_underrun, m_under);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; sclk = 1'b0; ss_n = 1'b1; mosi = 1'b0; tx_wr = 1'b0;
    word_mode = 2'd0; tx_data = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R10 reset state
    check(tx_empty && irq_tx, "R10", "tx_empty/irq_tx", {tx_empty, irq_tx}, 2'b11);
    check(!tx_underrun && !miso_oe && !miso, "R10", "underrun/oe/miso",
          {tx_underrun, miso_oe, miso}, 0);
    check(!rx_valid && !irq_rx && !irq_berr, "R10", "rx/irq", {rx_valid, irq_rx, irq_berr}, 0);

    // R1: clocking while deselected
    n_irq_rx = 0; n_berr = 0; rxq.delete();
    begin
      int oe_seen;
      oe_seen = 0;
      for (int i = 0; i < 30; i++) begin
        mosi = 1'($urandom); sclk = 1'b1; wait_clk(HALF);
        if (miso_oe) oe_seen++;
        sclk = 1'b0; wait_clk(HALF);
      end
      check(oe_seen == 0 && rxq.size() == 0, "R1", "oe/bytes while deselected",
            32'(oe_seen + rxq.size()), 0);
      check(n_irq_rx == 0 && n_berr == 0, "R1", "irqs while deselected",
            n_irq_rx + n_berr, 0);
    end

    // R6 directed: load clears empty
    write_tx(24'h0000A5);
    wait_clk(1);
    check(!tx_empty && !irq_tx, "R6", "empty after write", tx_empty, 0);

    txn(2'd0, 1, 0, 0, 0);          // 8-bit, trailing start underruns
    write_tx(24'h00C3F0);
    check(!tx_underrun, "R7", "underrun cleared by write", tx_underrun, 0);
    txn(2'd1, 2, 0, 1, 0);          // 16-bit, R9 reload with fresh data
    write_tx(24'h5A3C96);
    txn(2'd2, 3, 0, 3, 0);          // 24-bit, three words
    txn(2'd1, 2, 0, 0, 0);          // R7 starved: repeat
    write_tx(24'h123456);
    txn(2'd1, 1, 5, 0, 0);          // R8 abort after 5 bits
    txn(2'd0, 2, 0, 2, 0);          // fresh start after abort
    write_tx(24'hFEDCBA);
    txn(2'd0, 2, 0, 1, 1);          // R3 mode change mid transaction
    txn(2'd3, 1, 0, 0, 0);          // R3 mode 3 is 24 bits
    txn(2'd2, 1, 23, 0, 0);         // R8 abort at last bit

    for (int r = 0; r < 36; r++) begin
      logic [1:0] m;
      int nw, ab;
      m = 2'($urandom);
      nw = 1 + int'($urandom % 3);
      ab = (($urandom % 4) == 0) ? 1 + int'($urandom % (blen(m) - 1)) : 0;
      if ($urandom % 2) write_tx(24'($urandom));
      txn(m, nw, ab, int'($urandom % 8), bit'(($urandom % 5) == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_800_000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule